// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Array

This block multiplies a stream of signed 8-bit activation vectors by a square matrix of signed 8-bit weights that stays resident in the array. It is a parameterised N×N grid of identical processing elements. The default is 4×4. Before computing, the weights are shifted into the grid from the top, one weight row per enabled cycle, and each element then holds its own weight. During computation each activation vector enters on the left edge. Element i of the vector is delayed by i cycles so that it meets the partial sums at the right time. Activations travel right one element per cycle. Partial sums travel down one element per cycle, and each element adds its own product to the sum it receives from above.

Every element talks only to its neighbours, and no element reads or writes storage while a computation runs. Each activation is therefore reused across its whole grid row. The column sums leaving the bottom edge pass through a delay whose length depends on the column. This realigns them, so a complete 32-bit result vector is presented at once with a valid flag. A global stall freezes every pipeline register, which lets a consumer apply backpressure without losing or duplicating results.

Top module: `sa_array`

## Requirements
- R1: While `wload_en` is high and `stall` is low, `wload_row` enters grid row 0 and every grid row passes its weight to the row below. After N such cycles, the row presented first sits in grid row N-1, so rows are presented bottom row first. Element j of `wload_row` (bits j*8 upward) is the weight for column j. Weights do not change in any other cycle.
- R2: `wload_done` is high exactly when the number of weight shifts since reset has reached N. A shift made while it is high starts a new count at 1, and reset clears it.
- R3: For an accepted vector `a`, where `a[i]` is bits i*8 upward of `act_row`, the result has `sum over i of a[i]*W[i][j]` in bits j*32 upward of `res_row`. `W[i][j]` is the weight held in grid row i, column j. The arithmetic is signed two's complement.
- R4: A vector accepted in a cycle with `act_valid` high and `stall` low produces `res_valid` and its result 2N-1 unstalled cycles later. With no stall in between, that is exactly cycle t+2N-1.
- R5: Vectors accepted in consecutive cycles give results in consecutive cycles, one valid cycle per accepted vector, in order of acceptance.
- R6: In a cycle with `stall` high, `res_valid` is low and no register changes. `res_row` and `wload_done` in the next cycle equal their values in the stalled cycle. Stalled cycles do not count toward the R4 latency.
- R7: A cycle with `act_valid` low produces no result, whatever `act_row` carries.
- R8: Synchronous reset clears every activation, partial-sum and valid register and the load count. `res_valid` and `wload_done` are low in the cycle after reset, and no earlier vector produces a result after it. Loaded weights survive reset and are used by later vectors.
- R9: Sums are kept at 32 bits with sign extension of each 16-bit product. With N=4, all activations and weights at -128 give 65536 in every column. Activations at 127 with weights at -128 give -65024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes all pipeline and weight registers |
| wload_en | input | 1 | Shift one weight row into the top of the grid |
| wload_row | input | N*8 | Weight row, column j at bits j*8 upward |
| wload_done | output | 1 | A full set of N weight rows is resident |
| act_valid | input | 1 | `act_row` carries a vector to multiply |
| act_row | input | N*8 | Activation vector, element i at bits i*8 upward |
| res_valid | output | 1 | `res_row` carries a finished result |
| res_row | output | N*32 | Column sums, column j at bits j*32 upward |

## Verification
A wrong weight or a broken partial-sum link in one element corrupts a single column, and it does so in every later result. It therefore shows at `res_row` 2N-1 cycles after the first vector reaches that element. A wrong skew or de-skew depth shifts a column by whole cycles. The column then mixes products from neighbouring vectors, or lands one cycle away from `res_valid`, and this shows as soon as two different vectors are sent back to back. A valid-path error shows as a missing, extra or early `res_valid` against the count of accepted vectors, and a stall that leaks shows as a change of `res_row` in the cycle after the stall.

// File: rtl/sa_pkg.sv
package sa_pkg;

    localparam int unsigned SA_N_DEF  = 4;
    localparam int unsigned SA_AW_DEF = 8;
    localparam int unsigned SA_SW_DEF = 32;

    // cycles an activation of grid row r waits before the left edge
    function automatic int unsigned sa_in_skew(input int unsigned r);
        return r;
    endfunction

    // cycles a column sum waits after the bottom edge to realign the row
    function automatic int unsigned sa_out_skew(input int unsigned n, input int unsigned c);
        return n - 1 - c;
    endfunction

    // register stages from accepting a vector to presenting its result
    function automatic int unsigned sa_latency(input int unsigned n);
        return 2 * n - 1;
    endfunction

endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst, en};
            assign dout = din;
        end else begin : g_reg
            typedef struct packed {
                logic [DEPTH-1:0][W-1:0] pipe;
            } dly_t;

            dly_t dly_d, dly_q;

            always_comb begin
                dly_d = dly_q;
                if (en) begin
                    dly_d.pipe[0] = din;
                    for (int k = 1; k < DEPTH; k++) begin
                        dly_d.pipe[k] = dly_q.pipe[k-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    dly_q <= '0;
                end else begin
                    dly_q <= dly_d;
                end
            end

            assign dout = dly_q.pipe[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
    parameter int unsigned AW = 8,
    parameter int unsigned SW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wshift,
    input  logic [AW-1:0] w_in,
    output logic [AW-1:0] w_out,
    input  logic [AW-1:0] a_in,
    output logic [AW-1:0] a_out,
    input  logic [SW-1:0] ps_in,
    output logic [SW-1:0] ps_out
);

    localparam int unsigned PW  = 2 * AW;
    localparam int unsigned EXT = SW - PW;

    typedef struct packed {
        logic [AW-1:0] act;
        logic [SW-1:0] psum;
    } pe_t;

    pe_t st_d, st_q;
    logic [AW-1:0] w_d, w_q;

    logic signed [PW-1:0] prod;
    logic [SW-1:0]        prod_ext;

    assign prod     = $signed(a_in) * $signed(w_q);
    assign prod_ext = {{EXT{prod[PW-1]}}, prod};

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.act  = a_in;
            st_d.psum = ps_in + prod_ext;
        end
    end

    always_comb begin
        w_d = wshift ? w_in : w_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // weights are held across reset on purpose
    always_ff @(posedge clk) begin
        w_q <= w_d;
    end

    assign w_out  = w_q;
    assign a_out  = st_q.act;
    assign ps_out = st_q.psum;

endmodule

// File: rtl/sa_array.sv
module sa_array
    import sa_pkg::*;
#(
    parameter int unsigned N  = SA_N_DEF,
    parameter int unsigned AW = SA_AW_DEF,
    parameter int unsigned SW = SA_SW_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            wload_en,
    input  logic [N*AW-1:0] wload_row,
    output logic            wload_done,
    input  logic            act_valid,
    input  logic [N*AW-1:0] act_row,
    output logic            res_valid,
    output logic [N*SW-1:0] res_row
);

    localparam int unsigned LAT = sa_latency(N);
    localparam int unsigned CW  = $clog2(N + 1);

    typedef struct packed {
        logic [CW-1:0] wcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic adv;
    logic wshift;
    logic vld_tail;

    logic [N-1:0][AW-1:0] act_gated;
    logic [N-1:0][AW-1:0] act_skewed;

    logic [AW-1:0] a_h  [N][N+1];
    logic [SW-1:0] ps_v [N+1][N];
    logic [AW-1:0] w_v  [N+1][N];

    logic [N-1:0][AW-1:0] unused_act_tail;
    logic [N-1:0][AW-1:0] unused_w_tail;

    assign adv       = !stall;
    assign wshift    = wload_en && !stall;
    assign act_gated = act_valid ? act_row : '0;

    // ---------------- weight-load count ----------------
    always_comb begin
        ctl_d = ctl_q;
        if (wshift) begin
            if (ctl_q.wcnt == CW'(N)) begin
                ctl_d.wcnt = CW'(1);
            end else begin
                ctl_d.wcnt = ctl_q.wcnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wload_done = (ctl_q.wcnt == CW'(N));

    // ---------------- input skew ----------------
    generate
        for (genvar i = 0; i < N; i++) begin : g_in
            sa_delay #(
                .W    (AW),
                .DEPTH(sa_in_skew(i))
            ) u_skew (
                .clk (clk),
                .rst (rst),
                .en  (adv),
                .din (act_gated[i]),
                .dout(act_skewed[i])
            );
            assign a_h[i][0]          = act_skewed[i];
            assign unused_act_tail[i] = a_h[i][N];
        end
    endgenerate

    // ---------------- grid edges ----------------
    generate
        for (genvar j = 0; j < N; j++) begin : g_top
            assign ps_v[0][j]       = '0;
            assign w_v[0][j]        = wload_row[j*AW +: AW];
            assign unused_w_tail[j] = w_v[N][j];
        end
    endgenerate

    // ---------------- processing grid ----------------
    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar j = 0; j < N; j++) begin : g_col
                sa_pe #(
                    .AW(AW),
                    .SW(SW)
                ) u_pe (
                    .clk   (clk),
                    .rst   (rst),
                    .en    (adv),
                    .wshift(wshift),
                    .w_in  (w_v[i][j]),
                    .w_out (w_v[i+1][j]),
                    .a_in  (a_h[i][j]),
                    .a_out (a_h[i][j+1]),
                    .ps_in (ps_v[i][j]),
                    .ps_out(ps_v[i+1][j])
                );
            end
        end
    endgenerate

    // ---------------- output de-skew ----------------
    generate
        for (genvar j = 0; j < N; j++) begin : g_out
            sa_delay #(
                .W    (SW),
                .DEPTH(sa_out_skew(N, j))
            ) u_deskew (
                .clk (clk),
                .rst (rst),
                .en  (adv),
                .din (ps_v[N][j]),
                .dout(res_row[j*SW +: SW])
            );
        end
    endgenerate

    // ---------------- valid path ----------------
    sa_delay #(
        .W    (1),
        .DEPTH(LAT)
    ) u_vld (
        .clk (clk),
        .rst (rst),
        .en  (adv),
        .din (act_valid),
        .dout(vld_tail)
    );

    assign res_valid = vld_tail && !stall;

endmodule

// File: rtl/sa_array_chk.sv
module sa_array_chk
    import sa_pkg::*;
#(
    parameter int unsigned N  = SA_N_DEF,
    parameter int unsigned AW = SA_AW_DEF,
    parameter int unsigned SW = SA_SW_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic            wload_en,
    input logic            wload_done,
    input logic            act_valid,
    input logic            res_valid,
    input logic [N*SW-1:0] res_row
);

    localparam int unsigned LAT = sa_latency(N);

    logic [15:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + 16'(act_valid && !stall) - 16'(res_valid);
        end
    end

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!res_valid && !wload_done));

    assert_hold_result_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(res_row));

    assert_hold_done_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(wload_done));

    assert_done_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wload_done) |-> $past(wload_en && !stall));

    assert_done_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(wload_done) |-> ($past(wload_en && !stall) || $past(rst)));

    assert_result_credit_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (inflight != 16'd0));

    assert_inflight_bound_R5: assert property (@(posedge clk) disable iff (rst)
        inflight <= 16'(LAT));

endmodule

bind sa_array sa_array_chk #(
    .N (N),
    .AW(AW),
    .SW(SW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .wload_en  (wload_en),
    .wload_done(wload_done),
    .act_valid (act_valid),
    .res_valid (res_valid),
    .res_row   (res_row)
);

// File: tb/tb_sa_array.sv
module tb_sa_array;

    localparam int N   = 4;
    localparam int AW  = 8;
    localparam int SW  = 32;
    localparam int LAT = 2 * N - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            stall = 1'b0;
    logic            wload_en = 1'b0;
    logic [N*AW-1:0] wload_row = '0;
    logic            wload_done;
    logic            act_valid = 1'b0;
    logic [N*AW-1:0] act_row = '0;
    logic            res_valid;
    logic [N*SW-1:0] res_row;

    always #4 clk = ~clk;

    sa_array #(.N(N), .AW(AW), .SW(SW)) dut (
        .clk(clk), .rst(rst), .stall(stall),
        .wload_en(wload_en), .wload_row(wload_row), .wload_done(wload_done),
        .act_valid(act_valid), .act_row(act_row),
        .res_valid(res_valid), .res_row(res_row)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model state
    logic signed [AW-1:0] wmod [N][N];
    int mcnt = 0;
    int ncyc = 0;
    bit prev_st = 0;
    logic [N*SW-1:0] prev_row = '0;
    int unexp = 0;

    logic [N*SW-1:0] qexp [64];
    int              qdue [64];
    string           qtag [64];
    int qh = 0, qt = 0, qn = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [255:0] actv, input logic [255:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actv, expv);
        end
    endtask

    function automatic logic [N*SW-1:0] expect_row(input logic [N*AW-1:0] a);
        logic [N*SW-1:0] r;
        for (int j = 0; j < N; j++) begin
            int s = 0;
            for (int i = 0; i < N; i++) begin
                s += int'($signed(a[i*AW +: AW])) * int'(wmod[i][j]);
            end
            r[j*SW +: SW] = SW'(s);
        end
        return r;
    endfunction

    function automatic logic [N*AW-1:0] pack_row(input logic [AW-1:0] v0, v1, v2, v3);
        return {v3, v2, v1, v0};
    endfunction

    task automatic step(input logic st, input logic wl, input logic [N*AW-1:0] wr,
                        input logic av, input logic [N*AW-1:0] ar, input string tag);
        @(negedge clk);
        stall = st; wload_en = wl; wload_row = wr; act_valid = av; act_row = ar;
        #1;
        chk(wload_done == (mcnt == N), "R2", "wload_done", 256'(wload_done), 256'(mcnt == N));
        if (prev_st) chk(res_row == prev_row, "R6", "res_row held after stall", 256'(res_row), 256'(prev_row));
        if (st) begin
            chk(!res_valid, "R6", "res_valid during stall", 256'(res_valid), 256'(0));
        end else if (res_valid) begin
            if (qn == 0) begin
                unexp++;
                chk(0, "R7", "unexpected res_valid", 256'(1), 256'(0));
            end else begin
                chk(qdue[qh] == ncyc, "R4", "result cycle", 256'(ncyc), 256'(qdue[qh]));
                chk(res_row == qexp[qh], qtag[qh], "res_row", 256'(res_row), 256'(qexp[qh]));
                qh = (qh + 1) % 64; qn--;
            end
        end else if (qn > 0 && qdue[qh] == ncyc) begin
            chk(0, "R5", "missing res_valid", 256'(0), 256'(1));
            qh = (qh + 1) % 64; qn--;
        end
        prev_row = res_row;
        prev_st  = st;
        if (av && !st) begin
            qexp[qt] = expect_row(ar); qdue[qt] = ncyc + LAT; qtag[qt] = tag;
            qt = (qt + 1) % 64; qn++;
        end
        if (wl && !st) begin
            for (int r = N - 1; r > 0; r--) wmod[r] = wmod[r-1];
            for (int j = 0; j < N; j++) wmod[0][j] = wr[j*AW +: AW];
            mcnt = (mcnt == N) ? 1 : mcnt + 1;
        end
        if (!st) ncyc++;
    endtask

    task automatic idle();
        step(0, 0, '0, 0, '0, "R3");
    endtask

    task automatic drain();
        while (qn > 0) idle();
        idle(); idle();
    endtask

    // rows supplied bottom grid row first (R1)
    task automatic load(input logic [AW-1:0] w [N][N], input bit rnd_stall);
        for (int r = N - 1; r >= 0; r--) begin
            logic [N*AW-1:0] row;
            for (int j = 0; j < N; j++) row[j*AW +: AW] = w[r][j];
            if (rnd_stall) while (($urandom % 3) == 0) step(1, 1, row, 0, '0, "R6");
            step(0, 1, row, 0, '0, "R1");
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; stall = 0; wload_en = 0; act_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk(!res_valid, "R8", "res_valid after reset", 256'(res_valid), 256'(0));
        chk(!wload_done, "R8", "wload_done after reset", 256'(wload_done), 256'(0));
        qh = 0; qt = 0; qn = 0; mcnt = 0; prev_st = 0; prev_row = res_row;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] w [N][N];
        void'($urandom(32'h5A17));
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wmod[i][j] = '0;

        do_reset();

        // R1: distinct weights, unit vectors read back individual grid rows
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w[i][j] = AW'(16 * i + j + 1);
        load(w, 0);
        idle();
        chk(wload_done, "R2", "done after N shifts", 256'(wload_done), 256'(1));
        for (int i = 0; i < N; i++) step(0, 0, '0, 1, (N*AW)'(1) << (i * AW), "R1");
        drain();

        // R4: single vector, latency checked by scoreboard
        step(0, 0, '0, 1, pack_row(8'd3, 8'hFE, 8'd7, 8'h81), "R4");
        drain();

        // R7: garbage data with act_valid low
        for (int k = 0; k < 10; k++) step(0, 0, '0, 0, (N*AW)'($urandom), "R7");
        drain();
        chk(unexp == 0, "R7", "no result from invalid cycles", 256'(unexp), 256'(0));

        // R5: back-to-back random vectors with random weights
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w[i][j] = AW'($urandom);
        load(w, 0);
        for (int k = 0; k < 24; k++) step(0, 0, '0, 1, (N*AW)'($urandom), "R5");
        drain();

        // R6: random stalls and gaps
        for (int k = 0; k < 300; k++)
            step(($urandom % 4) == 0, 0, '0, ($urandom % 3) != 0, (N*AW)'($urandom), "R6");
        drain();

        // R2/R6: reload with stalls; done drops after first shift, rises after N
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w[i][j] = AW'($urandom);
        load(w, 1);
        idle();
        for (int k = 0; k < 40; k++) step(0, 0, '0, 1, (N*AW)'($urandom), "R3");
        drain();

        // R9: full-scale operands
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w[i][j] = 8'h80;
        load(w, 0);
        step(0, 0, '0, 1, {N{8'h80}}, "R9");
        step(0, 0, '0, 1, {N{8'h7F}}, "R9");
        drain();

        // R8: reset mid-stream flushes pending vectors, weights retained
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w[i][j] = AW'($urandom);
        load(w, 0);
        for (int k = 0; k < 3; k++) step(0, 0, '0, 1, (N*AW)'($urandom), "R8");
        do_reset();
        unexp = 0;
        for (int k = 0; k < 3 * N; k++) idle();
        chk(unexp == 0, "R8", "no stale result after reset", 256'(unexp), 256'(0));
        for (int k = 0; k < 8; k++) step(0, 0, '0, 1, (N*AW)'($urandom), "R8");
        drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule